// File: doc/BRIEF.md
# Real-Time Clock Alarm Unit

This block is the alarm unit of a real-time clock. A timekeeping counter outside the block supplies the current time and date as BCD bytes (seconds, minutes, hours, day of month, month). It also supplies a one-cycle strobe each time the seconds advance. On every strobe the block compares that time against five programmable alarm bytes. A five-bit repeat code masks individual fields out of the comparison, so the same hardware can fire once per second, minute, hour, day, month or year.

A match sets a sticky alarm flag. The flag can drive an active-low, open-drain style interrupt pin, modelled as a data/enable pair. In normal power mode the pin follows the flag when the flag enable is set. In backup-power mode it also needs the backup alarm enable. Both enables clear at reset, so an alarm that happens during power-up is recorded only in the flag, and software can read it after boot. A read of the flags register returns the flag and clears it. The clear is seen by the following read.

Top module: `rtc_alarm_unit`

## Requirements
- R1: After reset, all alarm bytes, the control byte and the alarm flag read as zero, and the interrupt is released (irq_oe_o=0, irq_n_o=1).
- R2: Register addresses are 0 seconds, 1 minutes, 2 hours, 3 day of month, 4 month, 5 control and 6 flags. A write stores the full byte at addresses 0 to 5. A read pulse loads reg_rdata_o at the next clock edge, and the value is then stable.
- R3: Control bits [4:0] form the repeat code. Bit 0 masks seconds, bit 1 minutes, bit 2 hours, bit 3 day of month and bit 4 month. A masked field always matches, so code 11111 fires on every strobe and code 11110 fires only when the seconds are equal.
- R4: With repeat code 00000 the flag sets only when all five fields are equal. A difference in any single field, including the month, gives no alarm.
- R5: When the stored day-of-month byte is 00 and the repeat code is 00000, the alarm is off. No strobe sets the flag, even if the time inputs equal the alarm bytes.
- R6: The flag (flags register bit 6) sets only on a clock edge where tick_i is high and the unmasked fields match.
- R7: A read of address 6 returns the flag and clears it at the same edge, which also releases the interrupt. A later read returns 0. If a matching strobe comes in the same cycle as the read, the set wins and the flag stays 1.
- R8: With backup_i low, the interrupt is asserted (irq_oe_o=1, irq_n_o=0) exactly when the flag and the flag enable (control bit 7) are both 1.
- R9: With backup_i high, the interrupt is asserted only when the flag, the flag enable and the backup alarm enable (control bit 6) are all 1.
- R10: Whenever the interrupt is not asserted, irq_oe_o is 0 and irq_n_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle strobe when the seconds advance |
| sec_i | input | 8 | Current seconds, BCD |
| min_i | input | 8 | Current minutes, BCD |
| hour_i | input | 8 | Current hours, BCD |
| date_i | input | 8 | Current day of month, BCD |
| month_i | input | 8 | Current month, BCD |
| backup_i | input | 1 | High while running on backup power |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data, valid the cycle after reg_re_i |
| irq_n_o | output | 1 | Active-low interrupt level |
| irq_oe_o | output | 1 | Interrupt drive enable (0 means released) |

## Verification
The assertions assume that tick_i is a single-cycle pulse, that the time inputs are stable while it is high, and that the read and write strobes are never high together. Under these assumptions, every rise of the flag can be traced to a strobe, and every flags read with no strobe present clears it. The stimulus drives all inputs on falling edges and holds each strobe for exactly one cycle. It never overlaps read and write. It overlaps a read with a strobe only in the set-wins case that R7 describes. Time values are legal BCD, except for one deliberate day-of-month 00 that probes the disabled state.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
  localparam int unsigned FIELD_W  = 8;
  localparam int unsigned N_FIELDS = 5;
  localparam int unsigned ADDR_W   = 3;
  localparam int unsigned F_DATE   = 3;  // index of day-of-month field
  localparam int unsigned CTRL_AFE = 7;
  localparam int unsigned CTRL_ABE = 6;
  localparam int unsigned FLAG_BIT = 6;
endpackage

// File: rtl/rtc_alarm_regs.sv
module rtc_alarm_regs
  import rtc_alarm_pkg::*;
#(
  parameter int unsigned FW = FIELD_W,
  parameter int unsigned NF = N_FIELDS,
  parameter int unsigned AW = ADDR_W
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   we_i,
  input  logic                   re_i,
  input  logic [AW-1:0]          addr_i,
  input  logic [FW-1:0]          wdata_i,
  input  logic                   af_i,
  output logic [NF-1:0][FW-1:0]  alarm_o,
  output logic [FW-1:0]          ctrl_o,
  output logic [FW-1:0]          rdata_o,
  output logic                   flag_rd_o
);
  localparam logic [AW-1:0] CTRL_A = AW'(NF);
  localparam logic [AW-1:0] FLAG_A = AW'(NF + 1);

  logic [FW-1:0] rd_mux;

  for (genvar g = 0; g < NF; g++) begin : g_field
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            alarm_o[g] <= '0;
      else if (we_i && addr_i == AW'(g))      alarm_o[g] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         ctrl_o <= '0;
    else if (we_i && addr_i == CTRL_A)   ctrl_o <= wdata_i;
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NF; i++)
      if (addr_i == AW'(i)) rd_mux = alarm_o[i];
    if (addr_i == CTRL_A) rd_mux = ctrl_o;
    if (addr_i == FLAG_A) rd_mux[FLAG_BIT] = af_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= rd_mux;
  end

  assign flag_rd_o = re_i && (addr_i == FLAG_A);
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
  import rtc_alarm_pkg::*;
#(
  parameter int unsigned FW = FIELD_W,
  parameter int unsigned NF = N_FIELDS
) (
  input  logic [NF-1:0][FW-1:0] now_i,
  input  logic [NF-1:0][FW-1:0] alarm_i,
  input  logic [NF-1:0]         mask_i,
  output logic                  hit_o
);
  logic [NF-1:0] eq;

  for (genvar g = 0; g < NF; g++) begin : g_cmp
    assign eq[g] = mask_i[g] || (now_i[g] == alarm_i[g]);
  end

  assign hit_o = &eq;
endmodule

// File: rtl/rtc_alarm_flag.sv
module rtc_alarm_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic hit_i,
  input  logic clr_i,
  input  logic afe_i,
  input  logic abe_i,
  input  logic backup_i,
  output logic af_o,
  output logic irq_n_o,
  output logic irq_oe_o
);
  logic drive;

  // a fresh alarm outranks the read-clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               af_o <= 1'b0;
    else if (tick_i && hit_i)  af_o <= 1'b1;
    else if (clr_i)            af_o <= 1'b0;
  end

  assign drive    = af_o && afe_i && (!backup_i || abe_i);
  assign irq_oe_o = drive;
  assign irq_n_o  = !drive;
endmodule

// File: rtl/rtc_alarm_unit.sv
module rtc_alarm_unit
  import rtc_alarm_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic [FIELD_W-1:0] sec_i,
  input  logic [FIELD_W-1:0] min_i,
  input  logic [FIELD_W-1:0] hour_i,
  input  logic [FIELD_W-1:0] date_i,
  input  logic [FIELD_W-1:0] month_i,
  input  logic               backup_i,
  input  logic               reg_we_i,
  input  logic               reg_re_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [FIELD_W-1:0] reg_wdata_i,
  output logic [FIELD_W-1:0] reg_rdata_o,
  output logic               irq_n_o,
  output logic               irq_oe_o
);
  logic [N_FIELDS-1:0][FIELD_W-1:0] now, alarm;
  logic [FIELD_W-1:0]  ctrl;
  logic [N_FIELDS-1:0] rpt;
  logic hit, hit_en, alarm_off, flag_rd, af, afe, abe;
  logic unused_ctrl;

  assign now = {month_i, date_i, hour_i, min_i, sec_i};

  rtc_alarm_regs #(.FW(FIELD_W), .NF(N_FIELDS), .AW(ADDR_W)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .re_i(reg_re_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .af_i(af),
    .alarm_o(alarm), .ctrl_o(ctrl),
    .rdata_o(reg_rdata_o), .flag_rd_o(flag_rd)
  );

  assign rpt         = ctrl[N_FIELDS-1:0];
  assign afe         = ctrl[CTRL_AFE];
  assign abe         = ctrl[CTRL_ABE];
  assign unused_ctrl = ^ctrl;
  assign alarm_off   = (alarm[F_DATE] == '0) && (rpt == '0);

  rtc_alarm_match #(.FW(FIELD_W), .NF(N_FIELDS)) u_match (
    .now_i(now), .alarm_i(alarm), .mask_i(rpt), .hit_o(hit)
  );

  assign hit_en = hit && !alarm_off;

  rtc_alarm_flag u_flag (
    .clk_i, .rst_ni, .tick_i, .hit_i(hit_en), .clr_i(flag_rd),
    .afe_i(afe), .abe_i(abe), .backup_i,
    .af_o(af), .irq_n_o, .irq_oe_o
  );
endmodule

// File: rtl/rtc_alarm_chk.sv
module rtc_alarm_chk
  import rtc_alarm_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned NF = N_FIELDS
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          tick_i,
  input logic          reg_re_i,
  input logic [AW-1:0] reg_addr_i,
  input logic          backup_i,
  input logic          af_i,
  input logic          afe_i,
  input logic          abe_i,
  input logic          off_i,
  input logic          irq_n_o,
  input logic          irq_oe_o
);
  localparam logic [AW-1:0] FLAG_A = AW'(NF + 1);

  a_r6_flag_from_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(af_i) |-> $past(tick_i));

  a_r7_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_re_i && reg_addr_i == FLAG_A && af_i && !tick_i) |=> !af_i);

  a_r5_off_no_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (off_i && !af_i) |=> !af_i);

  a_r8_irq_needs_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_oe_o |-> (af_i && afe_i));

  a_r9_backup_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (backup_i && irq_oe_o) |-> abe_i);

  a_r10_released_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_oe_o |-> irq_n_o);
endmodule

bind rtc_alarm_unit rtc_alarm_chk #(.AW(rtc_alarm_pkg::ADDR_W), .NF(rtc_alarm_pkg::N_FIELDS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i),
  .reg_re_i(reg_re_i), .reg_addr_i(reg_addr_i), .backup_i(backup_i),
  .af_i(af), .afe_i(afe), .abe_i(abe), .off_i(alarm_off),
  .irq_n_o(irq_n_o), .irq_oe_o(irq_oe_o)
);

// File: tb/rtc_alarm_unit_test.sv
`timescale 1ns/1ps
module rtc_alarm_unit_test;
  logic       clk_i = 0, rst_ni = 0, tick_i = 0, backup_i = 0;
  logic [7:0] sec_i = 0, min_i = 0, hour_i = 0, date_i = 0, month_i = 0;
  logic       reg_we_i = 0, reg_re_i = 0;
  logic [2:0] reg_addr_i = 0;
  logic [7:0] reg_wdata_i = 0;
  logic [7:0] reg_rdata_o;
  logic       irq_n_o, irq_oe_o;

  int total = 0, bad = 0;
  bit done = 0, pend = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  localparam logic [7:0] IRQ_ON = 8'h02, IRQ_OFF = 8'h01;

  always #2.5 clk_i = ~clk_i;

  rtc_alarm_unit uut (.*);

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: read issued at a posedge, data checked at next negedge
  always @(posedge clk_i) pend <= reg_re_i;
  always @(negedge clk_i) if (pend && exp_q.size() > 0)
    chk(tag_q.pop_front(), reg_rdata_o, exp_q.pop_front());

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk_i); reg_we_i = 1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i); reg_we_i = 0;
  endtask

  task automatic rd(logic [2:0] a, logic [7:0] e, string tag);
    @(negedge clk_i); reg_re_i = 1; reg_addr_i = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk_i); reg_re_i = 0;
  endtask

  task automatic set_time(logic [7:0] s, m, h, d, mo);
    sec_i = s; min_i = m; hour_i = h; date_i = d; month_i = mo;
  endtask

  task automatic tick(logic [7:0] s, m, h, d, mo);
    @(negedge clk_i); set_time(s, m, h, d, mo); tick_i = 1;
    @(negedge clk_i); tick_i = 0;
  endtask

  task automatic irq(logic [7:0] e, string tag);
    chk(tag, {6'b0, irq_oe_o, irq_n_o}, e);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    // R1 reset state
    for (int a = 0; a < 7; a++) rd(3'(a), 8'h00, "R1");
    irq(IRQ_OFF, "R1");

    // R2 program alarm 06-12 08:15:30, full match, flag enable
    wr(0, 8'h30); wr(1, 8'h15); wr(2, 8'h08); wr(3, 8'h12); wr(4, 8'h06);
    wr(5, 8'h80);
    rd(0, 8'h30, "R2"); rd(2, 8'h08, "R2"); rd(4, 8'h06, "R2"); rd(5, 8'h80, "R2");

    // R4 month differs
    tick(8'h30, 8'h15, 8'h08, 8'h12, 8'h07);
    irq(IRQ_OFF, "R4"); rd(6, 8'h00, "R4");
    // R6 matching time without strobe
    @(negedge clk_i); set_time(8'h30, 8'h15, 8'h08, 8'h12, 8'h06);
    repeat (2) @(negedge clk_i);
    rd(6, 8'h00, "R6");
    // R4/R8 full match
    tick(8'h30, 8'h15, 8'h08, 8'h12, 8'h06);
    irq(IRQ_ON, "R8");
    rd(6, 8'h40, "R7");
    irq(IRQ_OFF, "R7");
    rd(6, 8'h00, "R7");

    // R3 once per minute: only seconds compared
    wr(5, 8'h9E);
    tick(8'h31, 8'h16, 8'h09, 8'h13, 8'h07);
    rd(6, 8'h00, "R3");
    tick(8'h30, 8'h16, 8'h09, 8'h13, 8'h07);
    rd(6, 8'h40, "R3");
    // R3 every second
    wr(5, 8'h9F);
    tick(8'h59, 8'h59, 8'h23, 8'h28, 8'h02);
    rd(6, 8'h40, "R3");

    // R5 disabled: day 00 and code 00000, time equal to alarm bytes
    wr(3, 8'h00); wr(5, 8'h80);
    tick(8'h30, 8'h15, 8'h08, 8'h00, 8'h06);
    rd(6, 8'h00, "R5"); irq(IRQ_OFF, "R5");
    wr(3, 8'h12);

    // R8 flag enable off: flag set, pin released
    wr(5, 8'h1F);
    tick(8'h01, 8'h02, 8'h03, 8'h04, 8'h05);
    irq(IRQ_OFF, "R8"); rd(6, 8'h40, "R8");

    // R9 backup mode, flag enable only
    backup_i = 1;
    wr(5, 8'h9F);
    tick(8'h02, 8'h02, 8'h03, 8'h04, 8'h05);
    irq(IRQ_OFF, "R9");
    // R9 both enables
    wr(5, 8'hDF);
    irq(IRQ_ON, "R9");
    rd(6, 8'h40, "R9");
    irq(IRQ_OFF, "R10");
    backup_i = 0;

    // R7 set wins over simultaneous read-clear
    tick(8'h03, 8'h02, 8'h03, 8'h04, 8'h05);
    @(negedge clk_i);
    reg_re_i = 1; reg_addr_i = 6; tick_i = 1;
    exp_q.push_back(8'h40); tag_q.push_back("R7");
    @(negedge clk_i); reg_re_i = 0; tick_i = 0;
    rd(6, 8'h40, "R7");
    rd(6, 8'h00, "R7");
    irq(IRQ_OFF, "R10");

    repeat (3) @(negedge clk_i);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule